// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block keeps calendar time as a chain of BCD digit registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. A one-cycle enable pulse, normally once per second, advances the chain by one second. The hour digits run either as a 24-hour count or as a 12-hour count with a PM flag. Month ends follow Gregorian month lengths. February length comes from a small two-bit year-remainder field that software loads, not from the year digits.

A bus interface outside this block reaches every digit through one 4-bit write port and one 4-bit read port, both addressed by digit. A sequencer with four states drives each update. IDLE waits for the enable. On a sampled enable it moves to TIME, where seconds, minutes and hours step. From TIME it goes to DATE when the hour step crosses midnight, where weekday, day, month, year and remainder step, and otherwise straight to HOLD. HOLD lasts a parameterised number of cycles and then returns to IDLE. The busy output is high in every state except IDLE. The host uses it to avoid reading while the carry ripples. Writes and enables that arrive while busy is high are dropped.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the digits read as 00:00:00 in 24-hour mode, PM clear, weekday 0, day 01, month 01, year 00, remainder 0, and busy is low.
- R2: The digit addresses are 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units and 12 year tens. Addresses 13 to 15 read 0 and writes to them are dropped. Only the low bits of narrow digits are stored (seconds and minutes tens 3 bits, hours tens 2, weekday 3, day tens 2, month tens 1), and missing bits read 0.
- R3: Each accepted enable adds one second. Seconds and minutes wrap from 59 to 00 and carry into the next digit pair.
- R4: In 24-hour mode, hours wrap from 23 to 00 and that wrap advances the date.
- R5: In 12-hour mode, hours run 12, 1, ..., 11. The PM flag toggles on the step from 11 to 12. The date advances on the step from 11 PM to 12 AM.
- R6: The hours-tens address holds the hour tens in bits 1:0, the PM flag in bit 2 and 24-hour select in bit 3. A write with bit 3 set clears the PM flag.
- R7: Days wrap to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. The month then advances.
- R8: The day-tens address holds the day tens in bits 1:0 and the year remainder in bits 3:2. February ends on day 29 when the remainder is 0, and on day 28 otherwise.
- R9: After December 31 the date becomes January 01. The year advances, with 99 wrapping to 00, and the remainder advances modulo 4.
- R10: The weekday advances with each new day and wraps from 6 to 0.
- R11: Busy rises in the cycle after an enable is sampled while idle. It stays high for 1+HOLD_CYCLES cycles, or for 2+HOLD_CYCLES cycles when the update crosses midnight.
- R12: While busy is high, digit writes and further enables have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance enable |
| wr_en | input | 1 | Digit write strobe |
| wr_addr | input | 4 | Digit address for write |
| wr_data | input | 4 | Digit write value |
| rd_addr | input | 4 | Digit address for read |
| rd_data | output | 4 | Digit read value (combinational) |
| busy | output | 1 | Update in progress |

## Verification
The hardest states to reach are the year-end cascade and the February ends. In these, one enable ripples through every digit, the weekday and the remainder field, and only the remainder decides whether day 29 exists. Reaching them by counting seconds would take years of enables. So the stimulus loads a full calendar state just before the edge through the write port and then applies one to three enables. Random states are biased toward the last seconds of a minute, hour and day, and directed cases cover the leap and non-leap February, the 12-hour PM crossings, and New Year at year 99 with remainder 3.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DIG_W  = 4;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_SEC1  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_SEC10 = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_MIN1  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_MIN10 = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_HR1   = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_HR10  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_WDAY  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_DAY1  = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_DAY10 = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_MON1  = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_MON10 = 4'd10;
    localparam logic [ADDR_W-1:0] ADR_YR1   = 4'd11;
    localparam logic [ADDR_W-1:0] ADR_YR10  = 4'd12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TIME,
        ST_DATE,
        ST_HOLD
    } seq_state_t;

    // Last day of a month as two BCD digits; rem4 == 0 marks a leap year.
    function automatic logic [7:0] last_day_bcd(input logic [7:0] mon_bcd,
                                                input logic [1:0] rem4);
        logic [7:0] v;
        case (mon_bcd)
            8'h02:                      v = (rem4 == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: v = 8'h30;
            default:                    v = 8'h31;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic day_carry,
    output logic adv_time,
    output logic adv_date,
    output logic wr_open,
    output logic busy
);

    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hold_cnt <= '0;
        else if (state_nx != ST_HOLD) hold_cnt <= '0;
        else if (state == ST_HOLD)    hold_cnt <= hold_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (tick) state_nx = ST_TIME;
            ST_TIME: state_nx = day_carry ? ST_DATE : ST_HOLD;
            ST_DATE: state_nx = ST_HOLD;
            ST_HOLD: if (hold_cnt == HOLD_LAST) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        adv_time = 1'b0;
        adv_date = 1'b0;
        wr_open  = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin wr_open = 1'b1; busy = 1'b0; end
            ST_TIME: adv_time = 1'b1;
            ST_DATE: adv_date = 1'b1;
            ST_HOLD: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_time_stage.sv
module rtc_time_stage
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIG_W-1:0]  wr_data,
    output logic [3:0]        sec1,
    output logic [2:0]        sec10,
    output logic [3:0]        min1,
    output logic [2:0]        min10,
    output logic [3:0]        hr1,
    output logic [1:0]        hr10,
    output logic              pm,
    output logic              mode24,
    output logic              day_carry
);

    logic sec_wrap, min_wrap, hr_step, at_23, at_11, at_12;

    assign sec_wrap  = (sec1 == 4'd9) && (sec10 == 3'd5);
    assign min_wrap  = (min1 == 4'd9) && (min10 == 3'd5);
    assign hr_step   = sec_wrap && min_wrap;
    assign at_23     = (hr10 == 2'd2) && (hr1 == 4'd3);
    assign at_11     = (hr10 == 2'd1) && (hr1 == 4'd1);
    assign at_12     = (hr10 == 2'd1) && (hr1 == 4'd2);
    assign day_carry = adv && hr_step && (mode24 ? at_23 : (at_11 && pm));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec1 <= '0; sec10 <= '0; min1 <= '0; min10 <= '0;
            hr1 <= '0; hr10 <= '0; pm <= 1'b0; mode24 <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_SEC1:  sec1  <= wr_data;
                ADR_SEC10: sec10 <= wr_data[2:0];
                ADR_MIN1:  min1  <= wr_data;
                ADR_MIN10: min10 <= wr_data[2:0];
                ADR_HR1:   hr1   <= wr_data;
                ADR_HR10: begin
                    hr10   <= wr_data[1:0];
                    mode24 <= wr_data[3];
                    pm     <= wr_data[2] & ~wr_data[3];
                end
                default: ;
            endcase
        end else if (adv) begin
            if (sec1 == 4'd9) begin
                sec1  <= '0;
                sec10 <= (sec10 == 3'd5) ? 3'd0 : sec10 + 3'd1;
            end else begin
                sec1 <= sec1 + 4'd1;
            end
            if (sec_wrap) begin
                if (min1 == 4'd9) begin
                    min1  <= '0;
                    min10 <= (min10 == 3'd5) ? 3'd0 : min10 + 3'd1;
                end else begin
                    min1 <= min1 + 4'd1;
                end
            end
            if (hr_step) begin
                if (mode24 && at_23) begin
                    hr1 <= 4'd0; hr10 <= 2'd0;
                end else if (!mode24 && at_12) begin
                    hr1 <= 4'd1; hr10 <= 2'd0;
                end else if (!mode24 && at_11) begin
                    hr1 <= 4'd2; pm <= ~pm;
                end else if (hr1 == 4'd9) begin
                    hr1 <= 4'd0; hr10 <= hr10 + 2'd1;
                end else begin
                    hr1 <= hr1 + 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_date_stage.sv
module rtc_date_stage
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIG_W-1:0]  wr_data,
    output logic [2:0]        wday,
    output logic [3:0]        day1,
    output logic [1:0]        day10,
    output logic [1:0]        rem4,
    output logic [3:0]        mon1,
    output logic              mon10,
    output logic [3:0]        yr1,
    output logic [3:0]        yr10
);

    logic [7:0] last_day;
    logic       month_end, year_end;

    assign last_day  = last_day_bcd({3'd0, mon10, mon1}, rem4);
    assign month_end = ({2'd0, day10, day1} == last_day);
    assign year_end  = month_end && mon10 && (mon1 == 4'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wday <= '0; day1 <= 4'd1; day10 <= '0; rem4 <= '0;
            mon1 <= 4'd1; mon10 <= 1'b0; yr1 <= '0; yr10 <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_WDAY:  wday  <= wr_data[2:0];
                ADR_DAY1:  day1  <= wr_data;
                ADR_DAY10: begin
                    day10 <= wr_data[1:0];
                    rem4  <= wr_data[3:2];
                end
                ADR_MON1:  mon1  <= wr_data;
                ADR_MON10: mon10 <= wr_data[0];
                ADR_YR1:   yr1   <= wr_data;
                ADR_YR10:  yr10  <= wr_data;
                default: ;
            endcase
        end else if (adv) begin
            wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
            if (!month_end) begin
                if (day1 == 4'd9) begin
                    day1 <= 4'd0; day10 <= day10 + 2'd1;
                end else begin
                    day1 <= day1 + 4'd1;
                end
            end else begin
                day1 <= 4'd1; day10 <= 2'd0;
                if (year_end) begin
                    mon1 <= 4'd1; mon10 <= 1'b0;
                    rem4 <= rem4 + 2'd1;
                    if (yr1 == 4'd9) begin
                        yr1  <= 4'd0;
                        yr10 <= (yr10 == 4'd9) ? 4'd0 : yr10 + 4'd1;
                    end else begin
                        yr1 <= yr1 + 4'd1;
                    end
                end else if (mon1 == 4'd9) begin
                    mon1 <= 4'd0; mon10 <= 1'b1;
                end else begin
                    mon1 <= mon1 + 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
    import rtc_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DIG_W-1:0]  rd_data,
    output logic              busy
);

    logic adv_time, adv_date, wr_open, day_carry, wr_ok;
    logic [3:0] sec1, min1, hr1, day1, mon1, yr1, yr10;
    logic [2:0] sec10, min10, wday;
    logic [1:0] hr10, day10, rem4;
    logic       pm, mode24, mon10;
    logic [7:0] hr_view;

    assign wr_ok   = wr_en && wr_open;
    assign hr_view = {mode24, pm, hr10, hr1};

    rtc_seq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .day_carry(day_carry),
        .adv_time(adv_time), .adv_date(adv_date), .wr_open(wr_open), .busy(busy)
    );

    rtc_time_stage u_time (
        .clk(clk), .rst_n(rst_n), .adv(adv_time), .wr_en(wr_ok),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .sec1(sec1), .sec10(sec10), .min1(min1), .min10(min10),
        .hr1(hr1), .hr10(hr10), .pm(pm), .mode24(mode24), .day_carry(day_carry)
    );

    rtc_date_stage u_date (
        .clk(clk), .rst_n(rst_n), .adv(adv_date), .wr_en(wr_ok),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .wday(wday), .day1(day1), .day10(day10), .rem4(rem4),
        .mon1(mon1), .mon10(mon10), .yr1(yr1), .yr10(yr10)
    );

    always_comb begin
        case (rd_addr)
            ADR_SEC1:  rd_data = sec1;
            ADR_SEC10: rd_data = {1'b0, sec10};
            ADR_MIN1:  rd_data = min1;
            ADR_MIN10: rd_data = {1'b0, min10};
            ADR_HR1:   rd_data = hr1;
            ADR_HR10:  rd_data = hr_view[7:4];
            ADR_WDAY:  rd_data = {1'b0, wday};
            ADR_DAY1:  rd_data = day1;
            ADR_DAY10: rd_data = {rem4, day10};
            ADR_MON1:  rd_data = mon1;
            ADR_MON10: rd_data = {3'b000, mon10};
            ADR_YR1:   rd_data = yr1;
            ADR_YR10:  rd_data = yr10;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_chain_chk.sv
module rtc_bcd_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       busy,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [3:0] wr_data,
    input logic [3:0] rd_addr,
    input logic [3:0] rd_data,
    input logic [7:0] hr_view
);

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick) |=> busy);

    // R2
    spare_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > 4'd12) |-> (rd_data == 4'd0));

    // R6
    mode_clears_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr == 4'd5 && wr_data[3]) |=> (hr_view[7:6] == 2'b10));

    // R5
    pm_toggle_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hr_view[6]) && !$past(wr_en && !busy)) |-> (!hr_view[7] && hr_view[5:0] == 6'h12));

endmodule

bind rtc_bcd_chain rtc_bcd_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hr_view(hr_view)
);

// File: tb/rtc_bcd_chain_test.sv
module rtc_bcd_chain_test;

    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [3:0] rd_data;
    logic busy;

    int n_chk = 0, n_fail = 0;
    int s, mi, h, pm, m24, wd, d, mo, y, yr4;

    always #4 clk = ~clk;

    rtc_bcd_chain #(.HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    function automatic int mlen(int m, int r);
        if (m == 2) return (r == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_nib(int a);
        case (a)
            0: return s % 10;   1: return s / 10;
            2: return mi % 10;  3: return mi / 10;
            4: return h % 10;   5: return m24 * 8 + pm * 4 + h / 10;
            6: return wd;
            7: return d % 10;   8: return yr4 * 4 + d / 10;
            9: return mo % 10;  10: return mo / 10;
            11: return y % 10;  12: return y / 10;
            default: return 0;
        endcase
    endfunction

    task automatic day_step();
        wd = (wd == 6) ? 0 : wd + 1;
        if (d == mlen(mo, yr4)) begin
            d = 1;
            if (mo == 12) begin
                mo = 1; y = (y + 1) % 100; yr4 = (yr4 + 1) % 4;
            end else mo++;
        end else d++;
    endtask

    task automatic model_advance();
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0;
                if (m24 == 1) begin
                    h++;
                    if (h == 24) begin h = 0; day_step(); end
                end else if (h == 11) begin
                    h = 12; pm = 1 - pm;
                    if (pm == 0) day_step();
                end else if (h == 12) h = 1;
                else h++;
            end
        end
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        rd_addr = 4'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic check_all(string tag);
        int v;
        for (int a = 0; a < 13; a++) begin
            rd(a, v);
            check($sformatf("%s addr %0d", tag, a), v, exp_nib(a));
        end
    endtask

    task automatic wr(int a, int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 4'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_model();
        for (int a = 0; a < 13; a++) wr(a, exp_nib(a));
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (8) @(negedge clk);
        model_advance();
    endtask

    task automatic busy_len(string tag, int exp);
        int n = 0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        check(tag, n, exp);
        model_advance();
    endtask

    task automatic set_t(int hh, int mm, int ss, int p, int m);
        h = hh; mi = mm; s = ss; pm = p; m24 = m;
    endtask

    task automatic set_d(int w, int dd, int mm, int yy, int r);
        wd = w; d = dd; mo = mm; y = yy; yr4 = r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd20417));
        set_t(0, 0, 0, 0, 1); set_d(0, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check_all("R1");

        // R2 spare addresses and narrow digits
        wr(15, 9); wr(13, 5);
        for (int a = 13; a < 16; a++) begin rd(a, v); check("R2 spare", v, 0); end
        check_all("R2 after spare write");
        wr(1, 15); rd(1, v); check("R2 narrow sec10", v, 7);
        wr(10, 14); rd(10, v); check("R2 narrow mon10", v, 0);
        wr(1, 0);

        // R3 minute and hour carry
        set_t(14, 58, 59, 0, 1); set_d(2, 10, 6, 23, 3); load_model();
        tick_once(); check_all("R3 minute");
        set_t(14, 59, 59, 0, 1); load_model();
        tick_once(); check_all("R3 hour");

        // R4 and R11 midnight in 24-hour mode
        set_t(23, 59, 59, 0, 1); set_d(3, 14, 7, 41, 1); load_model();
        busy_len("R11 carry busy", 2 + HOLD);
        check_all("R4 midnight");
        busy_len("R11 plain busy", 1 + HOLD);
        check_all("R3 after midnight");

        // R5 12-hour sequence
        set_t(11, 59, 59, 0, 0); set_d(1, 5, 3, 10, 2); load_model();
        tick_once(); check_all("R5 11AM to 12PM");
        set_t(12, 59, 59, 1, 0); load_model();
        tick_once(); check_all("R5 12PM to 1PM");
        set_t(11, 59, 59, 1, 0); load_model();
        tick_once(); check_all("R5 11PM to 12AM");

        // R6 hours-tens control bits
        wr(5, 12); rd(5, v); check("R6 24h clears PM", v, 8);
        wr(5, 5);  rd(5, v); check("R6 12h PM", v, 5);

        // R7 month lengths
        set_t(23, 59, 59, 0, 1); set_d(4, 30, 4, 5, 1); load_model();
        tick_once(); check_all("R7 Apr30");
        set_t(23, 59, 59, 0, 1); set_d(4, 30, 5, 5, 1); load_model();
        tick_once(); check_all("R7 May30");
        set_t(23, 59, 59, 0, 1); set_d(4, 30, 9, 5, 1); load_model();
        tick_once(); check_all("R7 Sep30");

        // R8 February
        set_t(23, 59, 59, 0, 1); set_d(0, 28, 2, 21, 1); load_model();
        tick_once(); check_all("R8 Feb28 common");
        set_t(23, 59, 59, 0, 1); set_d(0, 28, 2, 24, 0); load_model();
        tick_once(); check_all("R8 Feb28 leap");
        set_t(23, 59, 59, 0, 1); load_model();
        tick_once(); check_all("R8 Feb29 leap");

        // R9 and R10 New Year at 99, weekday wrap
        set_t(23, 59, 59, 0, 1); set_d(6, 31, 12, 99, 3); load_model();
        tick_once(); check_all("R9 R10 new year");

        // R12 write and tick while busy
        set_t(10, 20, 30, 0, 1); set_d(2, 9, 8, 50, 2); load_model();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 4'd7;
        @(negedge clk); tick = 1'b0; wr_en = 1'b1; wr_addr = 4'd12; wr_data = 4'd3;
        @(negedge clk); wr_en = 1'b0;
        repeat (8) @(negedge clk);
        model_advance();
        check_all("R12 busy writes");

        // Random states biased toward rollovers (R3 R4 R5 R7 R8 R9 R10)
        for (int it = 0; it < 40; it++) begin
            int nt;
            m24 = $urandom_range(0, 1);
            if (m24 == 1) begin h = $urandom_range(0, 23); pm = 0; end
            else begin h = $urandom_range(1, 12); pm = $urandom_range(0, 1); end
            if ($urandom_range(0, 1) == 1) begin
                mi = 59; s = $urandom_range(57, 59);
                if (m24 == 1) h = 23; else begin h = 11; pm = 1; end
            end else begin
                mi = $urandom_range(0, 59); s = $urandom_range(0, 59);
            end
            mo = $urandom_range(1, 12); yr4 = $urandom_range(0, 3);
            y = $urandom_range(0, 99); wd = $urandom_range(0, 6);
            d = ($urandom_range(0, 1) == 1) ? mlen(mo, yr4) : $urandom_range(1, mlen(mo, yr4));
            load_model();
            nt = $urandom_range(1, 3);
            for (int k = 0; k < nt; k++) tick_once();
            check_all($sformatf("R3 random %0d", it));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule